// File: doc/BRIEF.md
# ASI Rate-Adaptation FIFO with Stuffing Insertion

This block moves 9-bit symbols from an application write clock to an internal read clock. Each symbol is an 8-bit transport byte plus a flag that marks it as a control character. The read side never stalls. On every read clock it emits one symbol. That symbol is the oldest stored entry when one is available. Otherwise it is the K28.5 comma, byte 8'hBC with the flag set. Because of this the read clock runs at its own fixed rate, and the application can write at any rate up to that rate, in bursts or with gaps.

Pointers cross between the two clock domains as Gray codes through two-flop synchronisers. Full is worked out on the write side and empty on the read side. A 2-bit mode field and an enable input together gate the whole function. A write-pointer reset discards all unread entries and restarts storage at address zero. A toggle handshake carries this reset across to the read side.

Top module: `asi_fill_fifo`

## Requirements
- R1: Every accepted write stores `wr_data` with `wr_kflag`. Accepted symbols leave on `sym_data`/`sym_kflag` unchanged, exactly once each, and in write order.
- R2: On each read clock where no stored entry is read, the output register loads the stuffing symbol: `sym_kflag`=1 with `sym_data`=8'hBC. After reset the output holds this symbol.
- R3: `fifo_full` is high while DEPTH entries (default 16) are stored as seen from the write side. A write attempted while `fifo_full` is high is dropped and leaves stored entries intact.
- R4: After reset `fifo_empty`=1 and `fifo_full`=0. While `fifo_empty` is high the read pointer does not advance.
- R5: The block is active only when `fifo_en`=1 and the mode field equals 2'b01. When inactive, writes are dropped and the output holds the stuffing symbol. Entries stored earlier are kept and drain once the block is active again.
- R6: The mode field resets to 2'b00. It loads 2'b01 on the write clock where `asi_sel` is first seen high after being low. A `cfg_wr` pulse loads `cfg_mode`, and this write takes priority over the `asi_sel` default.
- R7: A `wr_ptr_rst` pulse sets the write pointer to zero and discards every unread entry. `fifo_full` then reads high and writes are dropped until the read side has also returned to zero. After that, the next accepted word is the next symbol output.
- R8: A symbol written into an empty, active FIFO whose synchronisers have settled appears at the output after the third rising read-clock edge following its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Application write clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| fifo_en | input | 1 | Function enable |
| asi_sel | input | 1 | Transport-stream mode input; a rising level presets the mode field to 2'b01 |
| cfg_wr | input | 1 | Mode field write strobe |
| cfg_mode | input | 2 | Value loaded into the mode field |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Transport byte to store |
| wr_kflag | input | 1 | Control-character flag stored with the byte |
| wr_ptr_rst | input | 1 | Write-pointer reset / flush request |
| fifo_full | output | 1 | Full, or flush handshake pending (write domain) |
| rd_clk | input | 1 | Internal read clock, free running |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| sym_data | output | 8 | Output byte, one per read clock |
| sym_kflag | output | 1 | Output control-character flag |
| fifo_empty | output | 1 | No entry visible to the read side (read domain) |

## Verification
Timing of each result:
- **Full flag:** it follows a write on the same write edge. The bench samples it at the next falling write edge, before the next write is driven.
- **Stored symbol:** it reaches the output on the third rising read edge after its write edge (two synchroniser stages plus the output register). The latency check counts those read edges and samples each one at the falling edge that follows.
- **Mode and enable changes:** these take two read edges to reach the read side.
- **Flush handshake:** it needs about two read and two write edges.

For these slower cases the bench waits a fixed margin of read cycles before it samples. A scoreboard checks every non-stuffing output at the falling read edge, and write-side stimulus changes only on falling write edges.

// File: rtl/asi_fifo_pkg.sv
package asi_fifo_pkg;

    typedef struct packed {
        logic       ctrl;
        logic [7:0] data;
    } sym_t;

    localparam sym_t       STUFF_SYM = '{ctrl: 1'b1, data: 8'hBC};
    localparam logic [1:0] MODE_ASI  = 2'b01;

endpackage

// File: rtl/asi_sync2.sv
module asi_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= d;
            stable_q <= meta_q;
        end
    end

    assign q = stable_q;

endmodule

// File: rtl/asi_sym_store.sv
module asi_sym_store
    import asi_fifo_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  sym_t          wdata,
    input  logic [AW-1:0] raddr,
    output sym_t          rdata
);

    sym_t mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/asi_wr_ctrl.sv
module asi_wr_ctrl
    import asi_fifo_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          asi_sel,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_mode,
    input  logic          wr_en,
    input  logic          wr_ptr_rst,
    input  logic [PW-1:0] rgray_sync,
    input  logic          ack_sync,
    output logic [PW-1:0] wgray,
    output logic          flush_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic          fifo_full,
    output logic          active
);

    typedef struct packed {
        logic [PW-1:0] wbin;
        logic [PW-1:0] wgray;
        logic [1:0]    mode;
        logic          asi_prev;
        logic          req;
    } wr_state_t;

    wr_state_t     st_d, st_q;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] fill_w;
    logic          pending;
    logic          ptr_full;
    logic          full_w;
    logic          active_w;
    logic          accept;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        rbin_s   = gray_to_bin(rgray_sync);
        fill_w   = st_q.wbin - rbin_s;
        pending  = st_q.req ^ ack_sync;
        ptr_full = (st_q.wbin[PW-1] != rbin_s[PW-1]) &&
                   (st_q.wbin[AW-1:0] == rbin_s[AW-1:0]);
        full_w   = ptr_full | pending;
        active_w = fifo_en && (st_q.mode == MODE_ASI);
        accept   = wr_en && active_w && !full_w && !wr_ptr_rst;

        st_d          = st_q;
        st_d.asi_prev = asi_sel;
        if (cfg_wr) begin
            st_d.mode = cfg_mode;
        end else if (asi_sel && !st_q.asi_prev) begin
            st_d.mode = MODE_ASI;
        end

        if (wr_ptr_rst && !pending) begin
            st_d.wbin = '0;
            st_d.req  = ~st_q.req;
        end else if (accept) begin
            st_d.wbin = st_q.wbin + 1'b1;
        end
        st_d.wgray = st_d.wbin ^ (st_d.wbin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wgray     = st_q.wgray;
    assign flush_req = st_q.req;
    assign mem_we    = accept;
    assign mem_waddr = st_q.wbin[AW-1:0];
    assign fifo_full = full_w;
    assign active    = active_w;

    // R3: the write side never holds more than DEPTH entries
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> (fill_w <= PW'(DEPTH)));

    // R3: a write against a full FIFO does not move the pointer
    p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_en && !wr_ptr_rst) |=> (st_q.wbin == $past(st_q.wbin)));

    // R5: an inactive block stores nothing
    p_gate_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !wr_ptr_rst) |=> $stable(st_q.wbin));

    // R6: a rising mode input presets the field unless software writes it
    p_mode_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(asi_sel) && !cfg_wr) |=> (st_q.mode == MODE_ASI));

    // R7: pointer reset zeroes the pointer and blocks writes until acknowledged
    p_ptr_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr_rst && !pending) |=> (st_q.wbin == '0 && fifo_full));

endmodule

// File: rtl/asi_rd_ctrl.sv
module asi_rd_ctrl
    import asi_fifo_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wgray_sync,
    input  logic          req_sync,
    input  logic          active_sync,
    input  sym_t          mem_rdata,
    output logic [PW-1:0] rgray,
    output logic          flush_ack,
    output logic [AW-1:0] mem_raddr,
    output sym_t          out_sym,
    output logic          fifo_empty
);

    typedef struct packed {
        logic [PW-1:0] rbin;
        logic [PW-1:0] rgray;
        logic          ack;
        sym_t          out;
    } rd_state_t;

    rd_state_t     st_d, st_q;
    logic [PW-1:0] wbin_s;
    logic          empty_r;
    logic          flush;
    logic          fire;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        wbin_s  = gray_to_bin(wgray_sync);
        empty_r = (st_q.rbin == wbin_s);
        flush   = req_sync ^ st_q.ack;
        fire    = active_sync && !empty_r && !flush;

        st_d     = st_q;
        st_d.ack = req_sync;
        st_d.out = fire ? mem_rdata : STUFF_SYM;
        if (flush) begin
            st_d.rbin = '0;
        end else if (fire) begin
            st_d.rbin = st_q.rbin + 1'b1;
        end
        st_d.rgray = st_d.rbin ^ (st_d.rbin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.out <= STUFF_SYM;
        end else begin
            st_q <= st_d;
        end
    end

    assign rgray      = st_q.rgray;
    assign flush_ack  = st_q.ack;
    assign mem_raddr  = st_q.rbin[AW-1:0];
    assign out_sym    = st_q.out;
    assign fifo_empty = empty_r;

    // R2: any cycle without a read produces the comma fill symbol
    p_stuff_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (out_sym == STUFF_SYM));

    // R4: an empty FIFO never advances the read pointer
    p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && !flush) |=> $stable(st_q.rbin));

    // R5: an inactive read side outputs only fill symbols
    p_inactive_stuff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !active_sync |=> (out_sym == STUFF_SYM));

    // R7: a seen flush request returns the read pointer to zero
    p_flush_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.rbin == '0));

endmodule

// File: rtl/asi_fill_fifo.sv
module asi_fill_fifo
    import asi_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic       fifo_en,
    input  logic       asi_sel,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_mode,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_kflag,
    input  logic       wr_ptr_rst,
    output logic       fifo_full,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    output logic [7:0] sym_data,
    output logic       sym_kflag,
    output logic       fifo_empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wgray, rgray;
    logic [PW-1:0] wgray_rs, rgray_ws;
    logic          flush_req, flush_ack;
    logic          req_rs, ack_ws;
    logic          active_w, active_rs;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    sym_t          wr_sym, mem_rdata, out_sym;

    assign wr_sym = {wr_kflag, wr_data};

    asi_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .fifo_en    (fifo_en),
        .asi_sel    (asi_sel),
        .cfg_wr     (cfg_wr),
        .cfg_mode   (cfg_mode),
        .wr_en      (wr_en),
        .wr_ptr_rst (wr_ptr_rst),
        .rgray_sync (rgray_ws),
        .ack_sync   (ack_ws),
        .wgray      (wgray),
        .flush_req  (flush_req),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .fifo_full  (fifo_full),
        .active     (active_w)
    );

    asi_sym_store #(.DEPTH(DEPTH)) u_store (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (wr_sym),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    asi_sync2 #(.W(PW + 2)) u_sync_to_rd (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     ({wgray, flush_req, active_w}),
        .q     ({wgray_rs, req_rs, active_rs})
    );

    asi_sync2 #(.W(PW + 1)) u_sync_to_wr (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     ({rgray, flush_ack}),
        .q     ({rgray_ws, ack_ws})
    );

    asi_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk         (rd_clk),
        .rst_n       (rd_rst_n),
        .wgray_sync  (wgray_rs),
        .req_sync    (req_rs),
        .active_sync (active_rs),
        .mem_rdata   (mem_rdata),
        .rgray       (rgray),
        .flush_ack   (flush_ack),
        .mem_raddr   (mem_raddr),
        .out_sym     (out_sym),
        .fifo_empty  (fifo_empty)
    );

    assign sym_data  = out_sym.data;
    assign sym_kflag = out_sym.ctrl;

endmodule

// File: tb/asi_fill_fifo_bench.sv
`timescale 1ns/1ps
module asi_fill_fifo_bench;

    localparam int         DEPTH = 16;
    localparam logic [8:0] STUFF = 9'h1BC;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rd_run = 1'b1;
    logic       wr_rst_n, rd_rst_n;
    logic       fifo_en, asi_sel, cfg_wr, wr_en, wr_kflag, wr_ptr_rst;
    logic [1:0] cfg_mode;
    logic [7:0] wr_data;
    logic       fifo_full, fifo_empty, sym_kflag;
    logic [7:0] sym_data;
    logic [8:0] sym_now;

    int         nchk = 0;
    int         nerr = 0;
    bit         done = 1'b0;
    bit         mon_en = 1'b0;
    logic [8:0] exp_q [$];
    logic [1:0] mode_exp;
    logic       en_exp;
    int         full_hits = 0;

    assign sym_now = {sym_kflag, sym_data};

    asi_fill_fifo #(.DEPTH(DEPTH)) u_asi_fill_fifo (
        .wr_clk     (wr_clk),
        .wr_rst_n   (wr_rst_n),
        .fifo_en    (fifo_en),
        .asi_sel    (asi_sel),
        .cfg_wr     (cfg_wr),
        .cfg_mode   (cfg_mode),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_kflag   (wr_kflag),
        .wr_ptr_rst (wr_ptr_rst),
        .fifo_full  (fifo_full),
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .sym_data   (sym_data),
        .sym_kflag  (sym_kflag),
        .fifo_empty (fifo_empty)
    );

    // 50 MHz write clock; read clock on a non-integer grid so edges never meet
    always #10 wr_clk = ~wr_clk;
    initial begin
        #0.5;
        forever begin
            #17;
            rd_clk = rd_run ? ~rd_clk : 1'b0;
        end
    end

    function automatic bit act_exp();
        return en_exp && (mode_exp == 2'b01);
    endfunction

    function automatic logic [8:0] gen_word();
        logic [8:0] w;
        do begin
            w = 9'($urandom);
        end while (w == STUFF);
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // R1 scoreboard: every non-fill output must be the oldest accepted word
    always @(negedge rd_clk) begin
        if (mon_en && rd_rst_n && sym_now !== STUFF) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected symbol", 32'(sym_now), 32'(STUFF));
            end else begin
                check("R1 order/content", 32'(sym_now), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic wr_cycle(input logic en, input logic [8:0] w);
        @(negedge wr_clk);
        wr_en = en;
        {wr_kflag, wr_data} = w;
        if (fifo_full) full_hits++;
        if (en && act_exp() && !fifo_full) exp_q.push_back(w);
    endtask

    task automatic wait_rd(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic stop_rd();
        @(negedge rd_clk);
        rd_run = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge wr_clk);
        cfg_wr = 1'b1;
        cfg_mode = m;
        @(negedge wr_clk);
        cfg_wr = 1'b0;
        mode_exp = m;
    endtask

    initial begin
        #2_000_000;
        nerr++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int stored;
        int pct [3];
        logic [8:0] w;
        void'($urandom(32'd1357));
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        fifo_en = 1'b1; en_exp = 1'b1; asi_sel = 1'b0; mode_exp = 2'b00;
        cfg_wr = 1'b0; cfg_mode = 2'b00; wr_en = 1'b0; wr_data = '0;
        wr_kflag = 1'b0; wr_ptr_rst = 1'b0;
        repeat (4) @(negedge wr_clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        mon_en = 1'b1;

        // R4 / R2 reset state
        @(negedge wr_clk);
        check("R4 reset empty", 32'(fifo_empty), 1);
        check("R4 reset full", 32'(fifo_full), 0);
        check("R2 reset output", 32'(sym_now), 32'(STUFF));

        // R6 mode resets to 00, so R5 gating drops these writes
        for (int i = 0; i < 4; i++) wr_cycle(1'b1, gen_word());
        wr_cycle(1'b0, '0);
        wait_rd(10);
        check("R6 reset mode blocks writes", 32'(fifo_empty), 1);
        check("R5 inactive output", 32'(sym_now), 32'(STUFF));

        // R6 rising asi_sel presets mode 01
        @(negedge wr_clk);
        asi_sel = 1'b1;
        @(negedge wr_clk);
        mode_exp = 2'b01;
        wait_rd(6);

        // R5 enable low drops writes
        @(negedge wr_clk);
        fifo_en = 1'b0; en_exp = 1'b0;
        for (int i = 0; i < 3; i++) wr_cycle(1'b1, gen_word());
        wr_cycle(1'b0, '0);
        wait_rd(8);
        check("R5 enable low blocks writes", 32'(fifo_empty), 1);
        @(negedge wr_clk);
        fifo_en = 1'b1; en_exp = 1'b1;
        wait_rd(6);

        // R8 latency: third read edge after the write edge
        w = gen_word();
        @(negedge wr_clk);
        wr_en = 1'b1;
        {wr_kflag, wr_data} = w;
        exp_q.push_back(w);
        @(posedge wr_clk);
        wr_en <= 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(posedge rd_clk);
            @(negedge rd_clk);
            check("R8 latency", 32'(sym_now), (k < 3) ? 32'(STUFF) : 32'(w));
        end
        wait_rd(6);
        check("R1 single word drained", exp_q.size(), 0);

        // R3 fill to DEPTH with reads stalled, then overflow attempts
        stop_rd();
        stored = 0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            w = gen_word();
            @(negedge wr_clk);
            check("R3 full flag before write", 32'(fifo_full), (stored == DEPTH) ? 1 : 0);
            wr_en = 1'b1;
            {wr_kflag, wr_data} = w;
            if (stored < DEPTH) begin
                exp_q.push_back(w);
                stored++;
            end
        end
        wr_cycle(1'b0, '0);
        check("R3 full after overflow attempts", 32'(fifo_full), 1);
        rd_run = 1'b1;
        wait_rd(DEPTH + 12);
        check("R3 drained exactly DEPTH entries", exp_q.size(), 0);
        check("R4 empty after drain", 32'(fifo_empty), 1);
        check("R2 fill after drain", 32'(sym_now), 32'(STUFF));
        @(negedge wr_clk);
        check("R3 full clears", 32'(fifo_full), 0);

        // R5 retention while inactive, R6 software write of the mode field
        stop_rd();
        for (int i = 0; i < 4; i++) wr_cycle(1'b1, gen_word());
        wr_cycle(1'b0, '0);
        set_mode(2'b10);
        for (int i = 0; i < 3; i++) wr_cycle(1'b1, gen_word());
        wr_cycle(1'b0, '0);
        rd_run = 1'b1;
        wait_rd(15);
        check("R5 inactive holds fill", 32'(sym_now), 32'(STUFF));
        check("R5 entries retained", 32'(fifo_empty), 0);
        check("R5 retained count", exp_q.size(), 4);
        set_mode(2'b01);
        wait_rd(15);
        check("R6 cfg write reactivates", exp_q.size(), 0);

        // R7 write-pointer reset discards unread data
        stop_rd();
        for (int i = 0; i < 5; i++) wr_cycle(1'b1, gen_word());
        wr_cycle(1'b0, '0);
        @(negedge wr_clk);
        wr_ptr_rst = 1'b1;
        @(negedge wr_clk);
        wr_ptr_rst = 1'b0;
        exp_q.delete();
        check("R7 full while flush pending", 32'(fifo_full), 1);
        wr_cycle(1'b1, gen_word());
        wr_cycle(1'b0, '0);
        rd_run = 1'b1;
        wait_rd(12);
        check("R7 empty after flush", 32'(fifo_empty), 1);
        check("R7 full released", 32'(fifo_full), 0);
        check("R7 fill after flush", 32'(sym_now), 32'(STUFF));
        for (int i = 0; i < 3; i++) wr_cycle(1'b1, gen_word());
        wr_cycle(1'b0, '0);
        wait_rd(12);
        check("R7 new words drained", exp_q.size(), 0);

        // Random traffic at three write densities
        pct[0] = 90; pct[1] = 30; pct[2] = 60;
        for (int p = 0; p < 3; p++) begin
            for (int n = 0; n < 1000; n++) begin
                wr_cycle(($urandom % 100) < pct[p], gen_word());
            end
        end
        wr_cycle(1'b0, '0);
        wait_rd(40);
        check("R1 random traffic drained", exp_q.size(), 0);
        check("R3 full reached under bursts", 32'(full_hits > 0), 1);
        check("R2 fill at idle", 32'(sym_now), 32'(STUFF));
        check("R4 empty at idle", 32'(fifo_empty), 1);

        finish_run();
    end

endmodule